// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This block turns the low two single-precision floating-point lanes of a vector operand into two signed 32-bit integers, packed side by side into a 64-bit result. Lane *i* reads source bits `[32i+31:32i]` and writes result bits `[32i+31:32i]`. A caller presents the operand, a 16-bit control/status word and a mode bit together with a one-cycle `start` pulse. One clock later the block raises `done` for a single cycle. It then holds the packed integers and an updated status word until the next request.

The status word carries the rounding selection, the flush/denormal-as-zero controls and two sticky exception flags. The block never traps. Any lane whose value cannot be represented returns the integer-indefinite pattern `0x80000000` and sets the invalid flag. Any lane that loses fraction bits sets the precision flag. When the mode bit is high, conversion always chops toward zero and the rounding field is ignored.

Status word layout, used by every requirement below:
- bit 0: invalid flag
- bit 1: precision flag
- bits 3:2: rounding field (00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero)
- bit 4: flush-to-zero control
- bit 5: denormal-as-zero control
- bits 15:6: carried through unchanged

Top module: `f2i_pack_cvt`

## Requirements
- R1: Reset clears `done`, `result` and `stat_out` to zero. `done` is high in exactly the cycle after each cycle in which `start` is high, including back-to-back requests. `result` and `stat_out` change only in a cycle that follows a `start`.
- R2: A lane holding a NaN (exponent field 0xFF, fraction nonzero, quiet or signalling) or an infinity of either sign returns 0x80000000 and sets status bit 0. The other lane converts independently.
- R3: A finite lane whose value after rounding is 2^31 or more, or below -2^31, returns 0x80000000 and sets bit 0. This covers the largest finite normal of either sign. Exactly -2^31 (0xCF000000) returns 0x80000000 with no flag. 0x4EFFFFFF returns 2147483520.
- R4: With the mode bit low, rounding follows bits 3:2 (00 nearest with ties to even, 01 down, 10 up, 11 toward zero). Any discarded nonzero fraction sets status bit 1. For example, ±123456.1 gives 123456/−123456 under 00 and 11, 123456/−123457 under 01, and 123457/−123456 under 10. 2.5 and 3.5 give 2 and 4 under 00.
- R5: With the mode bit high, every lane chops toward zero whatever bits 3:2 hold. Bit 1 is still set when a fraction is discarded, so ±0.9 gives 0.
- R6: A denormal input with bit 5 clear is converted as its tiny value: 0 under nearest, with bit 1 set. With bit 5 set it is read as zero and no flag is raised. Bit 4 has no effect on any result, so ±0.9 under nearest gives ±1 with bit 4 set.
- R7: Exact inputs such as ±0, ±123456.0 and ±16777215.0 convert without raising any flag.
- R8: `stat_out` bits 15:2 equal `stat_in` bits 15:2. Bits 1:0 are the OR of the incoming flags and the flags of both lanes. A lane that is invalid never adds the precision flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; inputs sampled on this edge |
| trunc_mode | input | 1 | 1: chop toward zero, ignoring the rounding field |
| src | input | 64 | Two packed single-precision lanes, lane 0 in bits 31:0 |
| stat_in | input | 16 | Incoming control/status word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Two packed signed 32-bit integers |
| stat_out | output | 16 | Updated control/status word |

## Verification
The checker watches the handshake timing on every cycle. It also checks that outputs hold between requests, that control bits pass through, that flags stay sticky, and that lane 0 gives the indefinite result for all-ones exponents and zero for signed zero. Rounding direction per mode, tie-to-even behaviour, the −2^31 boundary, denormal handling under both settings of the denormal-as-zero bit, and the per-lane flag merge depend on specific operand values. Only the bench's directed scenarios show these, compared against its behavioural model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int FLT_W   = 32;
    localparam int FRAC_W  = 23;
    localparam int EXP_W   = 8;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int INT_W   = 32;

    // exponent at which the significand LSB has weight 1
    localparam int INT_BIAS = BIAS + FRAC_W;
    // exponent at which magnitude reaches 2^(INT_W-1)
    localparam int OVF_EXP  = BIAS + INT_W - 1;

    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    // status word bit positions
    localparam int STS_INV   = 0;
    localparam int STS_PREC  = 1;
    localparam int STS_RC_LO = 2;
    localparam int STS_FZ    = 4;
    localparam int STS_DAZ   = 5;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_DOWN    = 2'd1,
        RND_UP      = 2'd2,
        RND_ZERO    = 2'd3
    } rnd_e;

    typedef struct packed {
        logic              sign;
        logic              special;
        logic              zero;
        logic              big;
        logic [SIG_W-1:0]  sig;
        logic [EXP_W-1:0]  expn;
    } lane_cls_t;

    typedef struct packed {
        logic [INT_W-1:0] val;
        logic             inv;
        logic             prec;
    } lane_out_t;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [FLT_W-1:0] bits_in,
    input  logic             daz,
    output lane_cls_t        cls
);

    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        exp_raw     = bits_in[FLT_W-2 -: EXP_W];
        frac        = bits_in[FRAC_W-1:0];
        cls.sign    = bits_in[FLT_W-1];
        cls.special = &exp_raw;
        cls.zero    = (exp_raw == '0) && ((frac == '0) || daz);
        cls.sig     = {|exp_raw, frac};
        cls.expn    = (exp_raw == '0) ? EXP_W'(1) : exp_raw;
        cls.big     = !cls.special && (cls.expn >= EXP_W'(OVF_EXP));
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  lane_cls_t cls,
    input  rnd_e      rmode,
    input  logic      trunc,
    output lane_out_t lane_o
);

    localparam int EXT_W   = SIG_W + FRAC_W + 3;
    localparam int SHR_MAX = FRAC_W + 2;
    localparam int LSH_W   = 3;

    logic [LSH_W-1:0] lsh;
    logic [EXP_W-1:0] rsh;
    logic [EXT_W-1:0] wide;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] mag_r;
    logic             guard;
    logic             sticky;
    logic             inexact;
    logic             bump;

    always_comb begin
        lsh = LSH_W'(cls.expn - EXP_W'(INT_BIAS));
        rsh = EXP_W'(INT_BIAS) - cls.expn;
        if (rsh > EXP_W'(SHR_MAX)) begin
            rsh = EXP_W'(SHR_MAX);
        end
        wide   = {cls.sig, {(EXT_W-SIG_W){1'b0}}} >> rsh;
        mag    = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        if (cls.expn >= EXP_W'(INT_BIAS)) begin
            mag = INT_W'(cls.sig) << lsh;
        end else begin
            mag    = INT_W'(wide[EXT_W-1 -: SIG_W]);
            guard  = wide[EXT_W-SIG_W-1];
            sticky = |wide[EXT_W-SIG_W-2:0];
        end
        inexact = guard | sticky;

        unique case (rmode)
            RND_NEAREST: bump = guard & (sticky | mag[0]);
            RND_DOWN:    bump = cls.sign & inexact;
            RND_UP:      bump = ~cls.sign & inexact;
            default:     bump = 1'b0;
        endcase
        if (trunc) begin
            bump = 1'b0;
        end
        mag_r = mag + INT_W'(bump);

        lane_o.val  = cls.sign ? (~mag_r + INT_W'(1)) : mag_r;
        lane_o.inv  = 1'b0;
        lane_o.prec = inexact;
        if (cls.special) begin
            lane_o.val  = INDEF;
            lane_o.inv  = 1'b1;
            lane_o.prec = 1'b0;
        end else if (cls.zero) begin
            lane_o.val  = '0;
            lane_o.prec = 1'b0;
        end else if (cls.big) begin
            lane_o.val  = INDEF;
            lane_o.prec = 1'b0;
            lane_o.inv  = !(cls.sign && (cls.expn == EXP_W'(OVF_EXP)) &&
                            (cls.sig == {1'b1, {FRAC_W{1'b0}}}));
        end
    end

endmodule

// File: rtl/f2i_pack_cvt.sv
module f2i_pack_cvt
    import f2i_pkg::*;
#(
    parameter int LANES = 2,
    parameter int STS_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   trunc_mode,
    input  logic [LANES*FLT_W-1:0] src,
    input  logic [STS_W-1:0]       stat_in,
    output logic                   done,
    output logic [LANES*FLT_W-1:0] result,
    output logic [STS_W-1:0]       stat_out
);

    localparam int RES_W = LANES * FLT_W;

    typedef struct packed {
        logic             done;
        logic [RES_W-1:0] res;
        logic [STS_W-1:0] sts;
    } state_t;

    state_t     st_d;
    state_t     st_q;
    rnd_e       rmode;
    logic       daz;
    lane_out_t  lane_out [LANES];
    logic [RES_W-1:0] lane_vals;
    logic [STS_W-1:0] flag_vec;

    assign rmode = rnd_e'(stat_in[STS_RC_LO +: 2]);
    assign daz   = stat_in[STS_DAZ];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_cls_t cls;

        f2i_classify u_cls (
            .bits_in (src[g*FLT_W +: FLT_W]),
            .daz     (daz),
            .cls     (cls)
        );

        f2i_round u_rnd (
            .cls    (cls),
            .rmode  (rmode),
            .trunc  (trunc_mode),
            .lane_o (lane_out[g])
        );

        assign lane_vals[g*FLT_W +: FLT_W] = lane_out[g].val;
    end

    always_comb begin
        flag_vec = '0;
        for (int i = 0; i < LANES; i++) begin
            flag_vec[STS_INV]  = flag_vec[STS_INV]  | lane_out[i].inv;
            flag_vec[STS_PREC] = flag_vec[STS_PREC] | lane_out[i].prec;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.res = lane_vals;
            st_d.sts = stat_in | flag_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign result   = st_q.res;
    assign stat_out = st_q.sts;

endmodule

// File: rtl/f2i_pack_cvt_chk.sv
module f2i_pack_cvt_chk
    import f2i_pkg::*;
#(
    parameter int LANES = 2,
    parameter int STS_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [LANES*FLT_W-1:0] src,
    input logic [STS_W-1:0]       stat_in,
    input logic                   done,
    input logic [LANES*FLT_W-1:0] result,
    input logic [STS_W-1:0]       stat_out
);

    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(stat_out)));

    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stat_out[STS_W-1:STS_RC_LO] == $past(stat_in[STS_W-1:STS_RC_LO])));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((stat_out[STS_PREC:STS_INV] & $past(stat_in[STS_PREC:STS_INV]))
                   == $past(stat_in[STS_PREC:STS_INV])));

    a_r2_special_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (&src[FLT_W-2 -: EXP_W])) |=>
        ((result[FLT_W-1:0] == INDEF) && stat_out[STS_INV]));

    a_r7_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (src[FLT_W-2:0] == '0)) |=> (result[FLT_W-1:0] == '0));

endmodule

bind f2i_pack_cvt f2i_pack_cvt_chk #(.LANES(LANES), .STS_W(STS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .src      (src),
    .stat_in  (stat_in),
    .done     (done),
    .result   (result),
    .stat_out (stat_out)
);

// File: tb/sim_f2i_pack_cvt.sv
`timescale 1ns/1ps
module sim_f2i_pack_cvt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trunc_mode = 1'b0;
    logic [63:0] src = '0;
    logic [15:0] stat_in = '0;
    logic        done;
    logic [63:0] result;
    logic [15:0] stat_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    string cur_tag = "R1";
    string exp_tag = "R1";
    logic        exp_done = 1'b0;
    logic [63:0] exp_res = '0;
    logic [15:0] exp_sts = '0;

    always #10 clk = ~clk;

    f2i_pack_cvt u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .trunc_mode(trunc_mode),
        .src(src), .stat_in(stat_in), .done(done), .result(result),
        .stat_out(stat_out)
    );

    // behavioural reference for one lane
    function automatic void ref_lane(input logic [31:0] f, input logic [1:0] rc,
                                     input logic tr, input logic dz,
                                     output logic [31:0] r, output logic inv,
                                     output logic prec);
        int     e;
        int     sh;
        longint sig;
        longint mag;
        longint rem;
        longint half;
        logic   s;
        logic   up;
        e = int'(f[30:23]);
        s = f[31];
        inv = 1'b0; prec = 1'b0; r = '0;
        if (e == 255) begin
            inv = 1'b1; r = 32'h8000_0000;
            return;
        end
        if (e == 0 && (f[22:0] == 0 || dz)) return;
        sig = (e == 0) ? longint'(f[22:0]) : longint'(f[22:0]) + 64'sd8388608;
        if (e == 0) e = 1;
        sh = 150 - e;
        if (sh <= 0) begin
            mag = (-sh > 40) ? (64'sd1 <<< 40) : (sig <<< (-sh));
            rem = 0; half = 1;
        end else if (sh > 40) begin
            mag = 0; rem = sig; half = 64'sd1 <<< 40;
        end else begin
            mag = sig >>> sh;
            rem = sig - (mag <<< sh);
            half = 64'sd1 <<< (sh - 1);
        end
        prec = (rem != 0);
        up = 1'b0;
        if (!tr && rem != 0) begin
            case (rc)
                2'd0: up = (rem > half) || (rem == half && mag[0]);
                2'd1: up = s;
                2'd2: up = !s;
                default: up = 1'b0;
            endcase
        end
        mag = mag + (up ? 1 : 0);
        if (s ? (mag > 64'sd2147483648) : (mag >= 64'sd2147483648)) begin
            inv = 1'b1; prec = 1'b0; r = 32'h8000_0000;
        end else begin
            r = s ? 32'(-mag) : 32'(mag);
        end
    endfunction

    // expected state, advanced on the same edge as the design
    always @(posedge clk) begin
        logic [31:0] r0, r1;
        logic i0, i1, p0, p1;
        if (!rst_n) begin
            exp_done <= 1'b0;
            exp_res  <= '0;
            exp_sts  <= '0;
        end else begin
            exp_done <= start;
            if (start) begin
                ref_lane(src[31:0],  stat_in[3:2], trunc_mode, stat_in[5], r0, i0, p0);
                ref_lane(src[63:32], stat_in[3:2], trunc_mode, stat_in[5], r1, i1, p1);
                exp_res <= {r1, r0};
                exp_sts <= stat_in | {14'd0, p0 | p1, i0 | i1};
                exp_tag <= cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (done !== exp_done) begin
                errors++;
                $display("FAIL R1 done act=%b exp=%b at %0t", done, exp_done, $time);
            end
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result act=%h exp=%h at %0t", exp_tag, result, exp_res, $time);
            end
            checks++;
            if (stat_out !== exp_sts) begin
                errors++;
                $display("FAIL %s status act=%h exp=%h at %0t", exp_tag, stat_out, exp_sts, $time);
            end
        end
    end

    // caller is at a falling edge; leaves at a falling edge
    task automatic apply(input string tag, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [1:0] rc, input logic tr, input logic dz,
                         input logic fz, input logic [1:0] fl, input int gap);
        start      = 1'b1;
        src        = {hi, lo};
        trunc_mode = tr;
        stat_in    = {10'h2B6, dz, fz, rc, fl};
        cur_tag    = tag;
        @(negedge clk);
        start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic report;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired");
        report();
    end

    initial begin
        // R1: reset state observed by the per-cycle compare
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: exact values
        apply("R7", 32'h8000_0000, 32'h0000_0000, 2'd0, 0, 0, 0, 2'b00, 2);
        apply("R7", 32'hC7F1_2000, 32'h47F1_2000, 2'd0, 0, 0, 0, 2'b00, 2);
        apply("R7", 32'h4B7F_FFFF, 32'hCB7F_FFFF, 2'd2, 0, 0, 0, 2'b00, 2);

        // R4: rounding field
        apply("R4", 32'hC7F1_200D, 32'h47F1_200D, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R4", 32'hC7F1_200D, 32'h47F1_200D, 2'd1, 0, 0, 0, 2'b00, 1);
        apply("R4", 32'hC7F1_200D, 32'h47F1_200D, 2'd2, 0, 0, 0, 2'b00, 1);
        apply("R4", 32'hC7F1_200D, 32'h47F1_200D, 2'd3, 0, 0, 0, 2'b00, 1);
        apply("R4", 32'h4060_0000, 32'h4020_0000, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R4", 32'hC060_0000, 32'hC020_0000, 2'd0, 0, 0, 0, 2'b00, 1);

        // R5: truncating mode for every rounding field
        for (int k = 0; k < 4; k++) begin
            apply("R5", 32'hC7F1_200D, 32'h47F1_200D, 2'(k), 1, 0, 0, 2'b00, 1);
        end
        apply("R5", 32'h3F66_6666, 32'hBF66_6666, 2'd0, 1, 0, 1, 2'b00, 1);

        // R6: flush bit has no effect, denormals with and without DAZ
        apply("R6", 32'h3F66_6666, 32'hBF66_6666, 2'd0, 0, 0, 1, 2'b00, 1);
        apply("R6", 32'h8000_0001, 32'h007F_FFFF, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R6", 32'h807F_FFFF, 32'h0000_0001, 2'd0, 0, 1, 0, 2'b00, 1);
        apply("R6", 32'h8000_0001, 32'h007F_FFFF, 2'd2, 0, 0, 0, 2'b00, 1);
        apply("R6", 32'h8000_0001, 32'h007F_FFFF, 2'd1, 0, 0, 0, 2'b00, 1);

        // R2: NaN and infinity, and lane independence
        apply("R2", 32'h7F80_0000, 32'hFF80_0000, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R2", 32'hFF80_0001, 32'h7FC0_0000, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R2", 32'h7FC0_0000, 32'h3F80_0000, 2'd0, 0, 0, 0, 2'b00, 1);

        // R3: range boundaries
        apply("R3", 32'hFF7F_FFFF, 32'h7F7F_FFFF, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R3", 32'h4F00_0000, 32'hCF00_0000, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R3", 32'hCEFF_FFFF, 32'h4EFF_FFFF, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R3", 32'h8000_0000, 32'hCF00_0000, 2'd1, 0, 0, 0, 2'b00, 1);

        // R8: sticky flags, pass-through, merge of both lanes
        apply("R8", 32'h4B7F_FFFF, 32'h0000_0000, 2'd3, 0, 1, 1, 2'b11, 1);
        apply("R8", 32'h7FC0_0000, 32'h3F66_6666, 2'd0, 0, 0, 0, 2'b00, 1);
        apply("R8", 32'h7F80_0000, 32'h47F1_2000, 2'd2, 0, 0, 0, 2'b10, 1);

        // R1: back-to-back requests, then hold over idle cycles
        apply("R1", 32'hC7F1_200D, 32'h47F1_200D, 2'd2, 0, 0, 0, 2'b00, 0);
        apply("R1", 32'h4060_0000, 32'h4020_0000, 2'd0, 0, 0, 0, 2'b00, 0);
        apply("R1", 32'h7FC0_0000, 32'h3F66_6666, 2'd1, 0, 0, 0, 2'b00, 5);
        src = 64'hFFFF_FFFF_FFFF_FFFF;
        stat_in = 16'h00FF;
        repeat (4) @(negedge clk);

        report();
    end

endmodule